// File: doc/BRIEF.md
# Fan and GPIO Fault Latch Controller

This block is the fault-gathering core of a two-fan controller that also has four general-purpose pins. It looks at two fan tachometer channels and four GPIO inputs, and it records each enabled fault condition in a sticky fault register. Each tachometer channel gives an 8-bit count and a saturation flag. A host reaches the block through a small register bus. It presents a 3-bit address, a write strobe and a write byte, and it gets back a read byte in the same cycle. The bus has no handshake and no back-pressure. Every write is taken on the clock edge where `reg_wr` is high, and `reg_rdata` follows `reg_addr` combinationally.

A write to the fault register does not store the byte. It clears every latched fault bit. A condition that is still active raises its bit again on the next cycle. GPIO faults report changes, not levels. Each enabled pin is compared with a reference level, and that reference is re-captured both when the pin's enable goes from 0 to 1 and at every fault-register write. Two event inputs also set sticky flags in the fault register: a fan blast pulse and a serial-access time-out pulse. An interrupt line is high whenever any fault bit is set.

Top module: `fan_fault_ctrl`

## Requirements
- R1: After `rst_n` is held low for one clock edge, the registers read as follows. Fault reads 0x00, status 0x00, both fan levels 0x00, both tach counts 0xFF, GPIO setup 0x00, and the GPIO output nibble is 0xF. `irq` is 0.
- R2: Register addresses are 0 fault, 1 status, 2 fan A level, 3 fan B level, 4 tach A count, 5 tach B count, 6 GPIO data and 7 GPIO setup. Status bit 7 enables tach A faults and bit 6 enables tach B faults, and all other status bits read 0. GPIO setup bits 3:0 enable faults for pins 4..1, and bits 7:4 read 0. A GPIO data read returns the synchronised pin levels in bits 7:4 and the output nibble in bits 3:0.
- R3: Fault bit 7 (tach A) or bit 6 (tach B) sets one edge after a cycle in which that channel's enable bit is registered high and its overflow input is high. It never sets while the enable is low.
- R4: A tach fault stays set after the overflow input drops. A status write that clears its enable bit also clears the fault, on that same edge.
- R5: A write to address 0 clears all eight fault bits on its edge. The written byte is not stored.
- R6: If a tach overflow is still present, its fault reads 0 in the cycle right after a fault-register write and reads 1 again in the cycle after that.
- R7: A one-cycle pulse on `blast_evt` sets fault bit 5, and a pulse on `timeout_evt` sets fault bit 4. A fault-register write clears both. A pulse that arrives in the same cycle as that write is dropped.
- R8: Fault bit i-1 (pins 1..4 on bits 0..3) sets when its enable is high and the synchronised pin differs from the reference taken when the enable rose. A pin change shows in the fault register three edges after it reaches `gpio_in`. Clearing the enable clears the fault on the same edge.
- R9: A fault-register write re-captures each pin's reference. A pin that stays at its new level does not raise the fault again, and a later change away from that reference does raise it.
- R10: `irq` is 1 exactly when at least one fault bit is set.
- R11: A tach count register loads its input byte on an edge where its valid strobe is high and holds otherwise. Bus writes to the tach count addresses are ignored.
- R12: The fan level registers read back the last byte written to them. The GPIO output nibble reads back bits 3:0 of the last GPIO data write and drives `gpio_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, one write per high cycle |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte for `reg_addr` (combinational) |
| tach_a_vld | input | 1 | Load strobe for tach A count |
| tach_a_cnt | input | 8 | Tach A count value |
| tach_a_ovf | input | 1 | Tach A counter saturated beyond 255 |
| tach_b_vld | input | 1 | Load strobe for tach B count |
| tach_b_cnt | input | 8 | Tach B count value |
| tach_b_ovf | input | 1 | Tach B counter saturated beyond 255 |
| blast_evt | input | 1 | Fan blast event pulse |
| timeout_evt | input | 1 | Serial-access time-out pulse |
| gpio_in | input | 4 | Asynchronous GPIO pin levels |
| gpio_out | output | 4 | GPIO output nibble |
| dac_a | output | 8 | Fan A level register |
| dac_b | output | 8 | Fan B level register |
| irq | output | 1 | High while any fault bit is set |

## Verification
A wrong latched state in this block shows up at the ports without delay. A spurious or missing fault bit appears on the next fault read and on `irq` one edge after the bad update. A wrong GPIO reference only shows once the pin moves, three edges after the pin change at `gpio_in`. Lost clear priority shows as a fault read of 1 instead of 0 in the single cycle right after a clear write. The bench therefore samples each of these windows at an exact edge count and does not just wait for things to settle.

// File: rtl/fan_fault_pkg.sv
package fan_fault_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    A_FAULT  = 3'd0,
    A_STAT   = 3'd1,
    A_DACA   = 3'd2,
    A_DACB   = 3'd3,
    A_TACHA  = 3'd4,
    A_TACHB  = 3'd5,
    A_GDATA  = 3'd6,
    A_GSETUP = 3'd7
  } reg_addr_e;

  // fault register bit positions
  localparam int FB_TACHA = 7;
  localparam int FB_TACHB = 6;
  localparam int FB_BLAST = 5;
  localparam int FB_TIMER = 4;

  // status register enable positions
  localparam int SB_EN_A = 7;
  localparam int SB_EN_B = 6;

  // GPIO data read: pin levels start here
  localparam int GD_PIN_LSB = 4;
endpackage

// File: rtl/fan_sync.sv
module fan_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fan_tach_flag.sv
module fan_tach_flag #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] cnt_in,
  input  logic          ovf,
  input  logic          en,
  input  logic          en_nx,
  input  logic          clr,
  output logic [CW-1:0] cnt_q,
  output logic          flt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  cnt_q <= '1;
    else if (ld) cnt_q <= cnt_in;
  end

  // clear or disable beats set; a persisting condition returns next edge
  always_ff @(posedge clk) begin
    if (!rst_n)               flt_q <= 1'b0;
    else if (clr || !en_nx)   flt_q <= 1'b0;
    else if (en && ovf)       flt_q <= 1'b1;
  end
endmodule

// File: rtl/fan_gpio_flag.sv
module fan_gpio_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic en,
  input  logic en_nx,
  input  logic clr,
  output logic flt_q
);
  logic snap;

  always_ff @(posedge clk) begin
    if (!rst_n)                         snap <= 1'b0;
    else if (clr || (en_nx && !en))     snap <= lvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    flt_q <= 1'b0;
    else if (clr || !en_nx)        flt_q <= 1'b0;
    else if (en && (lvl != snap))  flt_q <= 1'b1;
  end
endmodule

// File: rtl/fan_event_flag.sv
module fan_event_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)    flag <= 1'b0;
    else if (clr)  flag <= 1'b0;
    else if (evt)  flag <= 1'b1;
  end
endmodule

// File: rtl/fan_fault_ctrl.sv
module fan_fault_ctrl
  import fan_fault_pkg::*;
#(
  parameter int NUM_GPIO    = 4,
  parameter int CW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  input  logic                tach_a_vld,
  input  logic [CW-1:0]       tach_a_cnt,
  input  logic                tach_a_ovf,
  input  logic                tach_b_vld,
  input  logic [CW-1:0]       tach_b_cnt,
  input  logic                tach_b_ovf,
  input  logic                blast_evt,
  input  logic                timeout_evt,
  input  logic [NUM_GPIO-1:0] gpio_in,
  output logic [NUM_GPIO-1:0] gpio_out,
  output logic [DW-1:0]       dac_a,
  output logic [DW-1:0]       dac_b,
  output logic                irq
);
  localparam int NCH = 2;

  logic wr_fault, wr_stat, wr_daca, wr_dacb, wr_gdata, wr_gsetup;
  logic flt_clr;

  assign wr_fault  = reg_wr && (reg_addr == A_FAULT);
  assign wr_stat   = reg_wr && (reg_addr == A_STAT);
  assign wr_daca   = reg_wr && (reg_addr == A_DACA);
  assign wr_dacb   = reg_wr && (reg_addr == A_DACB);
  assign wr_gdata  = reg_wr && (reg_addr == A_GDATA);
  assign wr_gsetup = reg_wr && (reg_addr == A_GSETUP);
  assign flt_clr   = wr_fault;

  // enable registers and their next values (used for same-edge disable)
  logic [NCH-1:0]      st_en, st_en_nx;
  logic [NUM_GPIO-1:0] g_en, g_en_nx;

  assign st_en_nx = wr_stat ? {reg_wdata[SB_EN_B], reg_wdata[SB_EN_A]} : st_en;
  assign g_en_nx  = wr_gsetup ? reg_wdata[NUM_GPIO-1:0] : g_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_en    <= '0;
      g_en     <= '0;
      dac_a    <= '0;
      dac_b    <= '0;
      gpio_out <= '1;
    end else begin
      st_en <= st_en_nx;
      g_en  <= g_en_nx;
      if (wr_daca)  dac_a    <= reg_wdata;
      if (wr_dacb)  dac_b    <= reg_wdata;
      if (wr_gdata) gpio_out <= reg_wdata[NUM_GPIO-1:0];
    end
  end

  // tachometer channels
  logic [NCH-1:0]         t_vld, t_ovf, t_flt;
  logic [NCH-1:0][CW-1:0] t_cnt_in, t_cnt_q;

  assign t_vld    = {tach_b_vld, tach_a_vld};
  assign t_ovf    = {tach_b_ovf, tach_a_ovf};
  assign t_cnt_in = {tach_b_cnt, tach_a_cnt};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_tach
    fan_tach_flag #(.CW(CW)) u_tach (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (t_vld[ch]),
      .cnt_in (t_cnt_in[ch]),
      .ovf    (t_ovf[ch]),
      .en     (st_en[ch]),
      .en_nx  (st_en_nx[ch]),
      .clr    (flt_clr),
      .cnt_q  (t_cnt_q[ch]),
      .flt_q  (t_flt[ch])
    );
  end

  // GPIO pins
  logic [NUM_GPIO-1:0] gpio_s, g_flt;

  fan_sync #(.W(NUM_GPIO), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (gpio_in),
    .q     (gpio_s)
  );

  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_gpio
    fan_gpio_flag u_gflag (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (gpio_s[g]),
      .en    (g_en[g]),
      .en_nx (g_en_nx[g]),
      .clr   (flt_clr),
      .flt_q (g_flt[g])
    );
  end

  // event flags
  logic blast_f, timer_f;

  fan_event_flag u_blast (
    .clk (clk), .rst_n (rst_n), .evt (blast_evt), .clr (flt_clr), .flag (blast_f)
  );
  fan_event_flag u_timer (
    .clk (clk), .rst_n (rst_n), .evt (timeout_evt), .clr (flt_clr), .flag (timer_f)
  );

  // fault register assembly
  logic [DW-1:0] fault_q;

  always_comb begin
    fault_q                = '0;
    fault_q[FB_TACHA]      = t_flt[0];
    fault_q[FB_TACHB]      = t_flt[1];
    fault_q[FB_BLAST]      = blast_f;
    fault_q[FB_TIMER]      = timer_f;
    fault_q[NUM_GPIO-1:0]  = g_flt;
  end

  assign irq = |fault_q;

  // read multiplexer
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_FAULT:  reg_rdata = fault_q;
      A_STAT: begin
        reg_rdata[SB_EN_A] = st_en[0];
        reg_rdata[SB_EN_B] = st_en[1];
      end
      A_DACA:   reg_rdata = dac_a;
      A_DACB:   reg_rdata = dac_b;
      A_TACHA:  reg_rdata[CW-1:0] = t_cnt_q[0];
      A_TACHB:  reg_rdata[CW-1:0] = t_cnt_q[1];
      A_GDATA: begin
        reg_rdata[NUM_GPIO-1:0]            = gpio_out;
        reg_rdata[GD_PIN_LSB +: NUM_GPIO]  = gpio_s;
      end
      A_GSETUP: reg_rdata[NUM_GPIO-1:0] = g_en;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fan_fault_ctrl_chk.sv
module fan_fault_ctrl_chk #(
  parameter int NG = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    fault_q,
  input logic          clr,
  input logic [1:0]    t_en,
  input logic [1:0]    t_ovf,
  input logic [NG-1:0] g_en,
  input logic          blast_evt,
  input logic          tach_a_vld,
  input logic [7:0]    tach_a_q
);
  // R5
  clear_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fault_q == 8'h00));

  // R3
  tach_a_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q[7] |-> t_en[0]);

  // R3
  tach_a_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q[7]) |-> $past(t_en[0] && t_ovf[0]));

  // R8
  gpio_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault_q[NG-1:0] & ~g_en) == '0));

  // R7
  blast_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blast_evt && !clr) |=> fault_q[5]);

  // R11
  tach_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tach_a_vld |=> $stable(tach_a_q));
endmodule

bind fan_fault_ctrl fan_fault_ctrl_chk #(.NG(NUM_GPIO)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fault_q    (fault_q),
  .clr        (flt_clr),
  .t_en       (st_en),
  .t_ovf      (t_ovf),
  .g_en       (g_en),
  .blast_evt  (blast_evt),
  .tach_a_vld (tach_a_vld),
  .tach_a_q   (t_cnt_q[0])
);

// File: tb/fan_fault_ctrl_test.sv
`timescale 1ns/1ps
module fan_fault_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tach_a_vld = 0, tach_a_ovf = 0, tach_b_vld = 0, tach_b_ovf = 0;
  logic [7:0] tach_a_cnt = '0, tach_b_cnt = '0;
  logic       blast_evt = 0, timeout_evt = 0;
  logic [3:0] gpio_in = '0;
  logic [3:0] gpio_out;
  logic [7:0] dac_a, dac_b;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fan_fault_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tach_a_vld(tach_a_vld), .tach_a_cnt(tach_a_cnt), .tach_a_ovf(tach_a_ovf),
    .tach_b_vld(tach_b_vld), .tach_b_cnt(tach_b_cnt), .tach_b_ovf(tach_b_ovf),
    .blast_evt(blast_evt), .timeout_evt(timeout_evt),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .dac_a(dac_a), .dac_b(dac_b),
    .irq(irq)
  );

  localparam logic [2:0] AF = 3'd0, AS = 3'd1, ADA = 3'd2, ADB = 3'd3,
                         ATA = 3'd4, ATB = 3'd5, AGD = 3'd6, AGS = 3'd7;

  // {req[3:0], write addr, write data, read addr, expected}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {4'd12, ADA, 8'h5A, ADA, 8'h5A},  // R12 fan A level
    {4'd12, ADB, 8'hC3, ADB, 8'hC3},  // R12 fan B level
    {4'd12, AGD, 8'h36, AGD, 8'h06},  // R12 output nibble only
    {4'd2,  AGS, 8'hF0, AGS, 8'h00},  // R2 setup upper bits read 0
    {4'd2,  AS,  8'h3F, AS,  8'h00},  // R2 status low bits read 0
    {4'd11, ATA, 8'h00, ATA, 8'hFF},  // R11 tach write ignored
    {4'd5,  AF,  8'hFF, AF,  8'h00},  // R5 data not stored
    {4'd2,  AS,  8'hC0, AS,  8'hC0},  // R2 enable bits
    {4'd2,  AS,  8'h00, AS,  8'h00},  // R2
    {4'd12, AGD, 8'h0F, AGD, 8'h0F}   // R12
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [7:0] exp, input int rq);
    reg_addr = a;
    #1;
    n_run++;
    if (reg_rdata !== exp) begin
      n_fail++;
      $display("FAIL R%0d addr %0d: got %h expected %h", rq, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp);
    #1;
    n_run++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL R10 irq: got %b expected %b", irq, exp);
    end
  endtask

  initial begin
    #(20.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1 reset state
    chk(AF, 8'h00, 1); chk(AS, 8'h00, 1); chk(ADA, 8'h00, 1); chk(ADB, 8'h00, 1);
    chk(ATA, 8'hFF, 1); chk(ATB, 8'hFF, 1); chk(AGD, 8'h0F, 1); chk(AGS, 8'h00, 1);
    chk_irq(1'b0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][21:19], VEC[i][18:11]);
      chk(VEC[i][10:8], VEC[i][7:0], int'(VEC[i][25:22]));
    end

    // R3 no fault without enable
    tach_a_ovf = 1'b1;
    tick(2);
    chk(AF, 8'h00, 3);
    wr(AS, 8'h80);
    chk(AF, 8'h00, 3);
    tick(1);
    chk(AF, 8'h80, 3);
    chk_irq(1'b1);               // R10
    // R4 latched after condition drops
    tach_a_ovf = 1'b0;
    tick(2);
    chk(AF, 8'h80, 4);
    wr(AF, 8'h00);
    chk(AF, 8'h00, 5);           // R5
    tick(1);
    chk(AF, 8'h00, 5);
    chk_irq(1'b0);
    // R6 persisting overflow returns after one low cycle
    tach_a_ovf = 1'b1;
    tick(1);
    chk(AF, 8'h80, 3);
    wr(AF, 8'hFF);
    chk(AF, 8'h00, 6);
    tick(1);
    chk(AF, 8'h80, 6);
    // R4 disabling clears on the write edge
    wr(AS, 8'h00);
    chk(AF, 8'h00, 4);
    chk_irq(1'b0);
    tach_a_ovf = 1'b0;
    // R3 channel B on bit 6
    tach_b_ovf = 1'b1;
    wr(AS, 8'h40);
    tick(1);
    chk(AF, 8'h40, 3);
    wr(AS, 8'h00);
    tach_b_ovf = 1'b0;
    chk(AF, 8'h00, 4);

    // R11 count loads
    tach_a_cnt = 8'h37; tach_a_vld = 1'b1;
    tach_b_cnt = 8'h12; tach_b_vld = 1'b1;
    tick(1);
    tach_a_vld = 1'b0; tach_b_vld = 1'b0;
    tach_a_cnt = 8'hEE; tach_b_cnt = 8'hDD;
    tick(2);
    chk(ATA, 8'h37, 11);
    chk(ATB, 8'h12, 11);

    // R7 event flags
    blast_evt = 1'b1; tick(1); blast_evt = 1'b0;
    chk(AF, 8'h20, 7);
    timeout_evt = 1'b1; tick(1); timeout_evt = 1'b0;
    chk(AF, 8'h30, 7);
    chk_irq(1'b1);
    wr(AF, 8'h00);
    chk(AF, 8'h00, 7);
    // R7 pulse coincident with clear is dropped
    @(negedge clk);
    reg_addr = AF; reg_wdata = 8'h00; reg_wr = 1'b1; blast_evt = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; blast_evt = 1'b0;
    chk(AF, 8'h00, 7);

    // R8 GPIO change detection
    wr(AGS, 8'h01);
    tick(3);
    chk(AF, 8'h00, 8);
    gpio_in = 4'b0001;
    tick(2);
    chk(AF, 8'h00, 8);
    tick(1);
    chk(AF, 8'h01, 8);
    chk(AGD, 8'h1F, 2);
    chk_irq(1'b1);
    gpio_in = 4'b0000;
    tick(3);
    chk(AF, 8'h01, 8);
    // R9 snapshot at clear
    wr(AF, 8'h00);
    chk(AF, 8'h00, 9);
    tick(3);
    chk(AF, 8'h00, 9);
    gpio_in = 4'b0001;
    tick(3);
    chk(AF, 8'h01, 9);
    wr(AF, 8'h00);
    tick(4);
    chk(AF, 8'h00, 9);
    gpio_in = 4'b0000;
    tick(3);
    chk(AF, 8'h01, 9);
    // R8 disable clears and blocks
    wr(AGS, 8'h00);
    chk(AF, 8'h00, 8);
    gpio_in = 4'b0001;
    tick(3);
    chk(AF, 8'h00, 8);
    // R8 pin 4 maps to bit 3
    wr(AGS, 8'h08);
    gpio_in = 4'b1001;
    tick(3);
    chk(AF, 8'h08, 8);
    wr(AGS, 8'h00);
    gpio_in = 4'b0000;

    // R1 reset in mid-run
    wr(ADA, 8'hA5);
    blast_evt = 1'b1; tick(1); blast_evt = 1'b0;
    rst_n = 1'b0;
    tick(1);
    rst_n = 1'b1;
    chk(AF, 8'h00, 1);
    chk(ADA, 8'h00, 1);
    chk(ATA, 8'hFF, 1);
    chk(AGD, 8'h0F, 1);
    chk_irq(1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule